// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the front end through which a host talks to a NOR-style flash controller. Every bus write hands it an address and a data word. The low byte of that word is a command code. The block picks which source later reads come from: the storage array, the identifier area, the query area or the status byte. It also recognises two-write sequences for erasing a block, programming one location and changing lock bits.

When a sequence is complete and valid, the block raises a start request toward an operation engine. The request carries the operation kind, the target address and the data. A sequence whose second write carries the wrong confirm code starts nothing and is reported in the status byte. The engine reports back three things: whether it is busy, whether it is suspended, and any error flags it wants recorded.

The engine, the array and the query contents are not part of this block. The `rd_src` output tells the surrounding logic which source to drive onto the read bus.

Top module: `flash_cui`

## Requirements
- R1: After reset the following hold: `rd_src` is 0 (array), `req_valid` is 0, and the four sticky status bits are 0. With the engine idle, `status_byte` then reads 80h.
- R2: Each of these single writes sets `rd_src` from the next cycle on: code FFh gives 0 (array), 90h gives 1 (identifier), 98h gives 2 (query) and 70h gives 3 (status).
- R3: While the engine is active (`eng_busy`=1 and `eng_suspended`=0), code FFh leaves `rd_src` unchanged. While the engine is suspended, FFh selects the array.
- R4: A first-cycle code outside the recognised set (FFh, 90h, 98h, 70h, 50h, 20h, 40h, 10h, 60h) changes neither `rd_src` nor `status_byte`.
- R5: Writing 20h and then D0h raises `req_valid` with `req_op`=0 (erase) and `req_addr` equal to the address of the D0h write.
- R6: Writing 40h or 10h, and then any word, raises `req_valid` with `req_op`=1 (program), and with `req_addr` and `req_data` taken from that second write.
- R7: Writing 60h and then 01h raises `req_op`=2 (set lock bit) with the second write's address. Writing 60h and then D0h raises `req_op`=3 (clear all lock bits).
- R8: In an erase or lock sequence, a second write with any other code starts no request and sets status bits 5 and 4.
- R9: After any operation setup write, `rd_src` is 3 (status). Once raised, `req_valid`, `req_op`, `req_addr` and `req_data` hold steady until `req_ready` is sampled high; `req_valid` is then 0 in the next cycle.
- R10: Code 50h clears status bits 5, 4, 3 and 1 when the engine is neither busy nor suspended. Otherwise the code is ignored.
- R11: The bits of `status_byte` are as follows. Bit 7 is the inverse of `eng_busy`. Bit 6 is `eng_suspended`. Bits 5, 4, 3 and 1 are sticky and are set by `eng_err_set[3]`, `[2]`, `[1]` and `[0]` respectively. Bits 2 and 0 read 0.
- R12: An operation setup code (20h, 40h, 10h or 60h) is ignored while the engine is active or while a request is still pending. The write after it is then decoded as a first-cycle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the low byte is the command code |
| eng_busy | input | 1 | Engine is running an operation |
| eng_suspended | input | 1 | Engine holds a suspended operation |
| eng_err_set | input | 4 | Engine error pulses for status bits 5, 4, 3 and 1 |
| req_ready | input | 1 | Engine accepts the pending request |
| req_valid | output | 1 | Start request pending |
| req_op | output | 2 | 0 erase, 1 program, 2 set lock, 3 clear locks |
| req_addr | output | ADDR_W | Target address of the request |
| req_data | output | DATA_W | Program data of the request |
| rd_src | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| status_byte | output | 8 | Status byte |

## Verification
Each write is sampled on one rising edge, and its effect on `rd_src`, `req_*` and the sticky status bits is due in the cycle straight after that edge. The same one-cycle delay applies to an `eng_err_set` pulse, and `req_valid` drops in the cycle after `req_ready` is sampled. Status bits 7 and 6 follow the engine inputs in the same cycle. The bench drives every input on the falling edge. It reads results on the next falling edge, so that exactly one rising edge lies between stimulus and check. Cases that should be ignored are judged by reading `rd_src`, `status_byte` and `req_valid` before the next stimulus.

// File: rtl/fcui_pkg.sv
package fcui_pkg;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_QUERY  = 2'd2,
        SRC_STATUS = 2'd3
    } rd_src_e;

    typedef enum logic [1:0] {
        OP_ERASE    = 2'd0,
        OP_PROGRAM  = 2'd1,
        OP_LOCK_SET = 2'd2,
        OP_LOCK_CLR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ERASE = 2'd1,
        SEQ_PROG  = 2'd2,
        SEQ_LOCK  = 2'd3
    } seq_e;

    typedef enum logic [3:0] {
        K_NONE, K_RD_ARRAY, K_RD_IDENT, K_RD_QUERY, K_RD_STATUS,
        K_CLEAR, K_ERASE_SU, K_PROG_SU, K_LOCK_SU
    } kind_e;

    localparam logic [7:0] C_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] C_RD_IDENT  = 8'h90;
    localparam logic [7:0] C_RD_QUERY  = 8'h98;
    localparam logic [7:0] C_RD_STATUS = 8'h70;
    localparam logic [7:0] C_CLEAR     = 8'h50;
    localparam logic [7:0] C_ERASE_SU  = 8'h20;
    localparam logic [7:0] C_PROG_SU_A = 8'h40;
    localparam logic [7:0] C_PROG_SU_B = 8'h10;
    localparam logic [7:0] C_LOCK_SU   = 8'h60;
    localparam logic [7:0] C_CONFIRM   = 8'hD0;
    localparam logic [7:0] C_LOCK_ONE  = 8'h01;

    localparam int STICKY_N = 4;

    typedef struct packed {
        logic issue;
        op_e  op;
        logic seq_err;
        logic clr;
    } seq_evt_t;

    function automatic kind_e classify(input logic [7:0] code);
        case (code)
            C_RD_ARRAY:               return K_RD_ARRAY;
            C_RD_IDENT:               return K_RD_IDENT;
            C_RD_QUERY:               return K_RD_QUERY;
            C_RD_STATUS:              return K_RD_STATUS;
            C_CLEAR:                  return K_CLEAR;
            C_ERASE_SU:               return K_ERASE_SU;
            C_PROG_SU_A, C_PROG_SU_B: return K_PROG_SU;
            C_LOCK_SU:                return K_LOCK_SU;
            default:                  return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fcui_seq.sv
module fcui_seq
    import fcui_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] code,
    input  logic       eng_busy,
    input  logic       eng_suspended,
    input  logic       req_pending,
    output rd_src_e    rd_src,
    output seq_e       state,
    output seq_evt_t   evt
);

    kind_e kind;
    logic  engine_active;
    logic  can_start;

    assign kind          = classify(code);
    assign engine_active = eng_busy && !eng_suspended;
    assign can_start     = !engine_active && !req_pending;

    always_comb begin
        evt = '{issue: 1'b0, op: OP_ERASE, seq_err: 1'b0, clr: 1'b0};
        if (wr_en) begin
            case (state)
                SEQ_IDLE: begin
                    evt.clr = (kind == K_CLEAR) && !eng_busy && !eng_suspended;
                end
                SEQ_ERASE: begin
                    evt.issue   = (code == C_CONFIRM);
                    evt.op      = OP_ERASE;
                    evt.seq_err = (code != C_CONFIRM);
                end
                SEQ_PROG: begin
                    evt.issue = 1'b1;
                    evt.op    = OP_PROGRAM;
                end
                SEQ_LOCK: begin
                    evt.issue   = (code == C_LOCK_ONE) || (code == C_CONFIRM);
                    evt.op      = (code == C_LOCK_ONE) ? OP_LOCK_SET : OP_LOCK_CLR;
                    evt.seq_err = (code != C_LOCK_ONE) && (code != C_CONFIRM);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            rd_src <= SRC_ARRAY;
        end else if (wr_en) begin
            if (state == SEQ_IDLE) begin
                case (kind)
                    K_RD_ARRAY:  if (!engine_active) rd_src <= SRC_ARRAY;
                    K_RD_IDENT:  rd_src <= SRC_IDENT;
                    K_RD_QUERY:  rd_src <= SRC_QUERY;
                    K_RD_STATUS: rd_src <= SRC_STATUS;
                    K_ERASE_SU: if (can_start) begin
                        state  <= SEQ_ERASE;
                        rd_src <= SRC_STATUS;
                    end
                    K_PROG_SU: if (can_start) begin
                        state  <= SEQ_PROG;
                        rd_src <= SRC_STATUS;
                    end
                    K_LOCK_SU: if (can_start) begin
                        state  <= SEQ_LOCK;
                        rd_src <= SRC_STATUS;
                    end
                    default: ;
                endcase
            end else begin
                state  <= SEQ_IDLE;
                rd_src <= SRC_STATUS;
            end
        end
    end

endmodule

// File: rtl/fcui_status.sv
module fcui_status
    import fcui_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                seq_err,
    input  logic                clr,
    input  logic [STICKY_N-1:0] eng_err_set,
    output logic [STICKY_N-1:0] sticky
);

    // index 3 -> bit 5, 2 -> bit 4 (both raised by sequence errors)
    localparam logic [STICKY_N-1:0] SEQ_MASK = 4'b1100;

    for (genvar i = 0; i < STICKY_N; i++) begin : g_bit
        logic set_now;
        assign set_now = eng_err_set[i] || (seq_err && SEQ_MASK[i]);
        always_ff @(posedge clk) begin
            if (rst)          sticky[i] <= 1'b0;
            else if (set_now) sticky[i] <= 1'b1;
            else if (clr)     sticky[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/fcui_req.sv
module fcui_req
    import fcui_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  op_e               op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ready,
    output logic              valid,
    output op_e               op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            op    <= OP_ERASE;
            addr  <= '0;
            data  <= '0;
        end else if (issue) begin
            valid <= 1'b1;
            op    <= op_in;
            addr  <= addr_in;
            data  <= data_in;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_cui.sv
module flash_cui
    import fcui_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    input  logic              eng_suspended,
    input  logic [3:0]        eng_err_set,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [1:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        rd_src,
    output logic [7:0]        status_byte
);

    rd_src_e              src_q;
    seq_e                 seq_state;
    seq_evt_t             evt;
    op_e                  op_q;
    logic [STICKY_N-1:0]  sticky;

    fcui_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .code          (wr_data[7:0]),
        .eng_busy      (eng_busy),
        .eng_suspended (eng_suspended),
        .req_pending   (req_valid),
        .rd_src        (src_q),
        .state         (seq_state),
        .evt           (evt)
    );

    fcui_status u_status (
        .clk         (clk),
        .rst         (rst),
        .seq_err     (evt.seq_err),
        .clr         (evt.clr),
        .eng_err_set (eng_err_set),
        .sticky      (sticky)
    );

    fcui_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .issue   (evt.issue),
        .op_in   (evt.op),
        .addr_in (wr_addr),
        .data_in (wr_data),
        .ready   (req_ready),
        .valid   (req_valid),
        .op      (op_q),
        .addr    (req_addr),
        .data    (req_data)
    );

    assign req_op      = op_q;
    assign rd_src      = src_q;
    assign status_byte = {~eng_busy, eng_suspended, sticky[3], sticky[2],
                          sticky[1], 1'b0, sticky[0], 1'b0};

endmodule

// File: rtl/fcui_chk.sv
module fcui_chk
    import fcui_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              eng_busy,
    input logic              eng_suspended,
    input logic [3:0]        eng_err_set,
    input logic              req_ready,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_data,
    input logic [1:0]        rd_src,
    input logic [7:0]        status_byte,
    input logic [1:0]        seq_state
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_src == 2'd0) && !req_valid);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
            && $stable(req_op) && $stable(req_data));

    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_valid);

    // R9
    start_shows_status_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> rd_src == 2'd3);

    // R3
    array_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && seq_state == SEQ_IDLE && wr_data[7:0] == 8'hFF
            && eng_busy && !eng_suspended |=> $stable(rd_src));

    // R8
    bad_confirm_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && seq_state == SEQ_ERASE && wr_data[7:0] != 8'hD0
            |=> status_byte[5] && status_byte[4] && !req_valid);

    // R10
    clear_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && seq_state == SEQ_IDLE && wr_data[7:0] == 8'h50
            && (eng_busy || eng_suspended) && eng_err_set == 4'd0
            |=> $stable(status_byte[5:3]) && $stable(status_byte[1]));

    // R12
    no_setup_pending_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && seq_state == SEQ_IDLE && req_valid |=> seq_state == SEQ_IDLE);

endmodule

bind flash_cui fcui_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .eng_busy      (eng_busy),
    .eng_suspended (eng_suspended),
    .eng_err_set   (eng_err_set),
    .req_ready     (req_ready),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_addr      (req_addr),
    .req_data      (req_data),
    .rd_src        (rd_src),
    .status_byte   (status_byte),
    .seq_state     (seq_state)
);

// File: tb/sim_flash_cui.sv
`timescale 1ns/1ps
module sim_flash_cui;

    localparam int AW = 21;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          eng_busy = 1'b0;
    logic          eng_suspended = 1'b0;
    logic [3:0]    eng_err_set = 4'd0;
    logic          req_ready = 1'b0;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [1:0]    rd_src;
    logic [7:0]    status_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_cui #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_busy(eng_busy), .eng_suspended(eng_suspended), .eng_err_set(eng_err_set),
        .req_ready(req_ready), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_src(rd_src),
        .status_byte(status_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd_src", rd_src, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 R11 status", status_byte, 8'h80);
    endtask

    task automatic t_read_modes();
        wr(0, 8'h90); chk("R2 ident", rd_src, 1);
        wr(0, 8'h98); chk("R2 query", rd_src, 2);
        wr(0, 8'h70); chk("R2 status", rd_src, 3);
        wr(0, 8'hFF); chk("R2 array", rd_src, 0);
    endtask

    task automatic t_unknown();
        wr(0, 8'h98);
        wr(0, 8'h33); chk("R4 src kept", rd_src, 2);
        chk("R4 status kept", status_byte, 8'h80);
        wr(0, 8'hD0); chk("R4 lone confirm", rd_src, 2);
        chk("R4 no req", req_valid, 0);
    endtask

    task automatic t_erase();
        wr(21'h0_1000, 8'h20);
        chk("R9 setup status", rd_src, 3);
        chk("R5 no req yet", req_valid, 0);
        wr(21'h1_2345, 8'hD0);
        chk("R5 valid", req_valid, 1);
        chk("R5 op", req_op, 0);
        chk("R5 addr", req_addr, 21'h1_2345);
        repeat (3) @(negedge clk);
        chk("R9 held", req_valid, 1);
        chk("R9 addr held", req_addr, 21'h1_2345);
        ack();
        chk("R9 dropped", req_valid, 0);
    endtask

    task automatic t_program();
        wr(0, 8'hFF);
        wr(0, 8'h40); chk("R9 prog status", rd_src, 3);
        wr(21'h0_0ABC, 8'h5A);
        chk("R6 op", req_op, 1);
        chk("R6 addr", req_addr, 21'h0_0ABC);
        chk("R6 data", req_data, 8'h5A);
        ack();
        wr(0, 8'h10);
        wr(21'h1F_FFFF, 8'hFF);
        chk("R6 alt valid", req_valid, 1);
        chk("R6 alt data", req_data, 8'hFF);
        ack();
    endtask

    task automatic t_lock();
        wr(0, 8'h60);
        wr(21'h0_3000, 8'h01);
        chk("R7 set op", req_op, 2);
        chk("R7 set addr", req_addr, 21'h0_3000);
        ack();
        wr(0, 8'h60);
        wr(21'h0_0007, 8'hD0);
        chk("R7 clr valid", req_valid, 1);
        chk("R7 clr op", req_op, 3);
        ack();
    endtask

    task automatic t_bad_confirm();
        wr(0, 8'h20);
        wr(21'h0_0100, 8'h55);
        chk("R8 erase no req", req_valid, 0);
        chk("R8 erase status", status_byte, 8'hB0);
        chk("R8 src", rd_src, 3);
        wr(0, 8'h50); chk("R10 clear", status_byte, 8'h80);
        wr(0, 8'h60);
        wr(0, 8'h77);
        chk("R8 lock no req", req_valid, 0);
        chk("R8 lock status", status_byte, 8'hB0);
    endtask

    task automatic t_clear();
        @(negedge clk); eng_err_set = 4'b0011;
        @(negedge clk); eng_err_set = 4'b0000;
        chk("R11 engine bits", status_byte, 8'hBA);
        eng_busy = 1'b1;
        wr(0, 8'h50); chk("R10 busy ignored", status_byte, 8'h3A);
        eng_busy = 1'b0; eng_suspended = 1'b1;
        wr(0, 8'h50); chk("R10 suspended ignored", status_byte, 8'hFA);
        eng_suspended = 1'b0;
        wr(0, 8'h50); chk("R10 cleared", status_byte, 8'h80);
    endtask

    task automatic t_busy_array();
        wr(0, 8'h70);
        eng_busy = 1'b1;
        wr(0, 8'hFF); chk("R3 blocked", rd_src, 3);
        eng_suspended = 1'b1;
        wr(0, 8'hFF); chk("R3 suspended", rd_src, 0);
        eng_busy = 1'b0; eng_suspended = 1'b0;
    endtask

    task automatic t_setup_blocked();
        eng_busy = 1'b1;
        wr(0, 8'h90);
        wr(0, 8'h20); chk("R12 busy setup", rd_src, 1);
        wr(0, 8'hD0); chk("R12 busy no req", req_valid, 0);
        eng_busy = 1'b0;
        wr(0, 8'h20);
        wr(21'h0_0200, 8'hD0);
        wr(0, 8'h90); chk("R2 ident pending", rd_src, 1);
        wr(0, 8'h40); chk("R12 pending setup", rd_src, 1);
        wr(21'h0_0999, 8'h12);
        chk("R12 op kept", req_op, 0);
        chk("R12 addr kept", req_addr, 21'h0_0200);
        ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_modes();
        t_unknown();
        t_erase();
        t_program();
        t_lock();
        t_bad_confirm();
        t_clear();
        t_busy_array();
        t_setup_blocked();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule